// File: doc/BRIEF.md
# Word-Wide Register Bank Behind a Two-Wire Serial Target

This block is a serial two-wire bus target (I2C-compatible, 7-bit addressing, no clock stretching) that gives a host access to a bank of 16-bit registers over a byte-wide link. It samples SCL and SDA in the system clock domain through a synchroniser. It recognises START, repeated START and STOP. It answers a device address whose upper five bits are fixed and whose two lowest bits are taken from strap pins, so that several copies can share one bus.

A host first writes a register pointer. In a write, byte pairs follow, high byte first. In a combined read, a repeated START and a read address follow, and the target then returns byte pairs. The pointer steps only after a whole 16-bit word has moved. The control registers drive a wide parallel output bus. Two status words are taken from input pins and are read-only. Addresses above the status words read as zero.

Top module: `i2c_wordreg_target`

## Requirements
- R1: The target answers only the 7-bit address {11010, strap[1:0]}. On any other address it leaves SDA released during the ninth clock and ignores all bus traffic until the next START.
- R2: The target acknowledges a matching address and every byte written to it by pulling SDA low (sda_oe=1) for the whole ninth SCL high phase.
- R3: After the pointer byte, written data comes in pairs, high byte first. The addressed control register changes only when the low byte of a pair arrives. A lone high byte followed by STOP changes nothing.
- R4: After each complete written word the pointer steps by one, so one burst fills consecutive registers.
- R5: In a combined read (address+write, pointer byte, repeated START, address+read), each register is returned as two bytes, the most significant first.
- R6: When the host acknowledges a low byte, the pointer steps and the next register's high byte follows. An acknowledged high byte is followed by the low byte of the same register.
- R7: When the host gives a not-acknowledge after a read byte, the target releases SDA at once and stays released until the next START.
- R8: Synchronous reset loads each control register with a default. Register 0x00 loads 0x0021 when mode_sel=1 and 0x0020 when mode_sel=0. Registers 0x01..0x05 load 0x0000, 0x0006, 0x0002, 0x0058 and 0x4F40. Every register n from 0x06 to 0x2E loads {n[7:0], n[7:0]}.
- R9: There are 47 control registers at 0x00..0x2E. Address 0x2F reads stat_in[15:0] and 0x30 reads stat_in[31:16]. Writes to 0x2F and 0x30 are acknowledged, have no effect, and still step the pointer.
- R10: Addresses 0x31..0xFF read as 0x0000. Writes to them have no effect.
- R11: A START or STOP at any bit position abandons the byte in progress. A repeated START in the middle of a data byte leads to a fresh address phase, and the partial byte has no effect.
- R12: The target changes sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap | input | 2 | Low two bits of the device address |
| mode_sel | input | 1 | Picks the reset default of register 0x00 |
| stat_in | input | 32 | Two read-only status words, 0x2F in bits 15:0 |
| ctrl_out | output | 752 | All control registers, register n in bits 16n+15:16n |

## Verification
Two events fall in the same cycle. When the low byte of a written pair completes, the register write and the pointer step both happen on one clock edge. The same holds on the read side, where the host's acknowledge both steps the pointer and starts the fetch of the next word. A burst that starts at the last control register and runs into the status words provokes this: the write at 0x2E must land, the pointer must step past it, and the next word must fall on a read-only location. A repeated START placed halfway through a data byte meets the byte shifter mid-count. These are judged at the pins, against a behavioural register image that the bench compares with the parallel outputs on every idle clock, and against the bytes the bench reads back.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int PTR_W = 8;
  localparam logic [4:0] DEV_HI = 5'b11010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WDATA, ST_ACK, ST_LOAD, ST_RDATA, ST_MACK
  } eng_state_t;

  function automatic logic [6:0] dev_addr(input logic [1:0] strap);
    return {DEV_HI, strap};
  endfunction

  function automatic logic [15:0] reg_default(input int idx, input logic mode);
    logic [7:0] n;
    n = 8'(idx);
    case (idx)
      0: return mode ? 16'h0021 : 16'h0020;
      1: return 16'h0000;
      2: return 16'h0006;
      3: return 16'h0002;
      4: return 16'h0058;
      5: return 16'h4F40;
      default: return {n, n};
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_wr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [1:0]       strap,
  input  logic [15:0]      rd_word,
  output logic [PTR_W-1:0] ptr,
  output logic             word_wr,
  output logic [15:0]      wr_word,
  output logic             sda_oe,
  output logic             addr_hit,
  output logic             addr_miss,
  output logic             rd_adv,
  output logic             rd_nack
);
  eng_state_t st, nxt;
  logic [2:0] bitcnt;
  logic [7:0] shreg, hi_hold, tx;
  logic       byte_full, lo_phase, mack;
  logic       byte_done, rx_state;
  logic [7:0] tx_sel;

  assign rx_state  = (st == ST_ADDR) || (st == ST_REG) || (st == ST_WDATA);
  assign byte_done = scl_fall && byte_full && rx_state;
  assign addr_hit  = byte_done && (st == ST_ADDR) && (shreg[7:1] == dev_addr(strap));
  assign addr_miss = byte_done && (st == ST_ADDR) && (shreg[7:1] != dev_addr(strap));
  assign word_wr   = byte_done && (st == ST_WDATA) && lo_phase;
  assign wr_word   = {hi_hold, shreg};
  assign rd_adv    = scl_fall && (st == ST_MACK) && mack && lo_phase;
  assign rd_nack   = scl_fall && (st == ST_MACK) && !mack;
  assign tx_sel    = lo_phase ? rd_word[7:0] : rd_word[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;      nxt <= ST_IDLE;   bitcnt <= '0;
      shreg <= '0;        hi_hold <= '0;    tx <= '0;
      byte_full <= 1'b0;  lo_phase <= 1'b0; mack <= 1'b0;
      ptr <= '0;          sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= ST_ADDR;  bitcnt <= '0;  byte_full <= 1'b0;
      lo_phase <= 1'b0;  sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE;  bitcnt <= '0;  byte_full <= 1'b0;  sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end else if (byte_done) begin
            byte_full <= 1'b0;
            sda_oe    <= 1'b1;
            st        <= ST_ACK;
            if (addr_miss) begin
              sda_oe <= 1'b0;
              st     <= ST_IDLE;
            end
            if (addr_hit) nxt <= shreg[0] ? ST_LOAD : ST_REG;
            if (st == ST_REG) begin
              ptr      <= shreg;
              lo_phase <= 1'b0;
              nxt      <= ST_WDATA;
            end
            if (st == ST_WDATA) begin
              nxt <= ST_WDATA;
              if (lo_phase) begin
                lo_phase <= 1'b0;
                ptr      <= ptr + PTR_W'(1);
              end else begin
                hi_hold  <= shreg;
                lo_phase <= 1'b1;
              end
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          st     <= nxt;
        end
        ST_LOAD: begin
          tx     <= tx_sel;
          sda_oe <= ~tx_sel[7];
          bitcnt <= '0;
          st     <= ST_RDATA;
        end
        ST_RDATA: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0;
            mack   <= 1'b0;
            st     <= ST_MACK;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
            bitcnt <= bitcnt + 3'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              st <= ST_LOAD;
              if (lo_phase) begin
                lo_phase <= 1'b0;
                ptr      <= ptr + PTR_W'(1);
              end else lo_phase <= 1'b1;
            end else st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_wr_bank.sv
module i2c_wr_bank
  import i2c_wr_pkg::*;
#(
  parameter int NUM_CTRL = 47,
  parameter int NUM_STAT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_sel,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         addr,
  input  logic [15:0]              wr_word,
  input  logic [NUM_STAT*16-1:0]   stat_in,
  output logic [15:0]              rd_word,
  output logic [NUM_CTRL*16-1:0]   ctrl_out
);
  localparam int STAT_BASE = NUM_CTRL;
  logic [15:0] ctrl_q [NUM_CTRL];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q[i] <= reg_default(i, mode_sel);
      else if (wr_en && addr == PTR_W'(i)) ctrl_q[i] <= wr_word;
    end
    assign ctrl_out[i*16 +: 16] = ctrl_q[i];
  end

  always_comb begin
    rd_word = 16'h0000;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addr == PTR_W'(i)) rd_word = ctrl_q[i];
    for (int j = 0; j < NUM_STAT; j++)
      if (addr == PTR_W'(STAT_BASE + j)) rd_word = stat_in[j*16 +: 16];
  end
endmodule

// File: rtl/i2c_wordreg_target.sv
module i2c_wordreg_target
  import i2c_wr_pkg::*;
#(
  parameter int NUM_CTRL    = 47,
  parameter int NUM_STAT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_oe,
  input  logic [1:0]             strap,
  input  logic                   mode_sel,
  input  logic [NUM_STAT*16-1:0] stat_in,
  output logic [NUM_CTRL*16-1:0] ctrl_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic addr_hit, addr_miss, word_wr, rd_adv, rd_nack;
  logic [PTR_W-1:0] ptr;
  logic [15:0] wr_word, rd_word;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wr_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .rd_word(rd_word), .ptr(ptr), .word_wr(word_wr),
    .wr_word(wr_word), .sda_oe(sda_oe), .addr_hit(addr_hit),
    .addr_miss(addr_miss), .rd_adv(rd_adv), .rd_nack(rd_nack)
  );

  i2c_wr_bank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_bank (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_en(word_wr),
    .addr(ptr), .wr_word(wr_word), .stat_in(stat_in), .rd_word(rd_word),
    .ctrl_out(ctrl_out)
  );
endmodule

// File: rtl/i2c_wordreg_checker.sv
module i2c_wordreg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       addr_hit,
  input logic       addr_miss,
  input logic       word_wr,
  input logic       rd_adv,
  input logic       rd_nack,
  input logic [7:0] ptr
);
  a_r1_miss_stays_silent: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);
  a_r2_hit_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> sda_oe);
  a_r4_write_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |=> ptr == $past(ptr) + 8'd1);
  a_r6_read_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |=> ptr == $past(ptr) + 8'd1);
  a_r7_nack_frees_line: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nack |=> !sda_oe);
  a_r11_stop_frees_line: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  a_r12_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));
endmodule

bind i2c_wordreg_target i2c_wordreg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .addr_hit(addr_hit),
  .addr_miss(addr_miss), .word_wr(word_wr), .rd_adv(rd_adv),
  .rd_nack(rd_nack), .ptr(ptr)
);

// File: tb/i2c_wordreg_target_test.sv
`timescale 1ns/1ps
module i2c_wordreg_target_test;
  localparam int NCTRL = 47;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic mode_sel = 1'b0;
  logic [31:0] stat_in = {16'hBEEF, 16'h1234};
  logic sda_oe;
  logic [NCTRL*16-1:0] ctrl_out;
  logic sda_line;

  int compared = 0, mismatched = 0, r12_bad = 0;
  logic cmp_en = 1'b0;
  logic prev_oe = 1'b0;
  logic [15:0] mdl [0:255];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_wordreg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap(strap), .mode_sel(mode_sel), .stat_in(stat_in), .ctrl_out(ctrl_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic logic [15:0] model_read(input int a);
    if (a < NCTRL) return mdl[a];
    if (a == NCTRL) return stat_in[15:0];
    if (a == NCTRL + 1) return stat_in[31:16];
    return 16'h0000;
  endfunction

  task automatic model_reset(input logic m);
    for (int k = 0; k < 256; k++) mdl[k] = {k[7:0], k[7:0]};
    mdl[0] = {8'h00, 7'b0010000, m};
    mdl[1] = 16'h0000; mdl[2] = 16'h0006; mdl[3] = 16'h0002;
    mdl[4] = 16'h0058; mdl[5] = 16'h4F40;
  endtask

  // register image compared with the parallel outputs on every idle clock (R3 R8 R9 R10)
  always @(negedge clk) begin
    if (cmp_en) begin
      compared++;
      for (int k = 0; k < NCTRL; k++) begin
        if (ctrl_out[k*16 +: 16] !== mdl[k]) begin
          mismatched++;
          $display("FAIL R3 image reg %0d actual=%h expected=%h", k, ctrl_out[k*16 +: 16], mdl[k]);
          break;
        end
      end
    end
    if (rst_n && sda_oe !== prev_oe && scl) r12_bad++;
    prev_oe = sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    cmp_en = 1'b0;
    sda_m = 1'b1; scl = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(4*Q);
    cmp_en = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wclk(Q);
      scl = 1'b1; wclk(2*Q);
      scl = 1'b0; wclk(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1; wclk(Q);
    ack = ~sda_line; wclk(Q);
    scl = 1'b0; wclk(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); scl = 1'b1; wclk(Q);
      b[i] = sda_line; wclk(Q);
      scl = 1'b0; wclk(Q);
    end
    sda_m = ~give_ack; wclk(Q);
    scl = 1'b1; wclk(2*Q);
    scl = 1'b0; wclk(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_burst(input logic [6:0] dev, input int reg_a, input logic [15:0] words[$]);
    logic ack;
    int p;
    p = reg_a;
    bus_start();
    send_byte({dev, 1'b0}, ack); chk("R2 addr ack", ack, 1'b1);
    send_byte(8'(reg_a), ack);   chk("R2 pointer ack", ack, 1'b1);
    foreach (words[k]) begin
      send_byte(words[k][15:8], ack); chk("R2 high ack", ack, 1'b1);
      send_byte(words[k][7:0], ack);  chk("R2 low ack", ack, 1'b1);
      if (p < NCTRL) mdl[p] = words[k];
      p = (p + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic read_burst(input logic [6:0] dev, input int reg_a, input int n, input string req);
    logic ack;
    logic [7:0] hi, lo;
    int p;
    p = reg_a;
    bus_start();
    send_byte({dev, 1'b0}, ack); chk("R5 write addr ack", ack, 1'b1);
    send_byte(8'(reg_a), ack);   chk("R5 pointer ack", ack, 1'b1);
    bus_rstart();
    send_byte({dev, 1'b1}, ack); chk("R5 read addr ack", ack, 1'b1);
    for (int k = 0; k < n; k++) begin
      recv_byte(1'b1, hi);
      recv_byte(k < n - 1, lo);
      chk(req, {hi, lo}, model_read(p));
      p = (p + 1) % 256;
    end
    wclk(2);
    chk("R7 released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary_and_end();
  end

  initial begin : main
    logic ack;
    logic [15:0] wq[$];
    // R8: defaults with mode_sel low
    mode_sel = 1'b0; rst_n = 1'b0; wclk(6); rst_n = 1'b1; wclk(2);
    model_reset(1'b0);
    chk("R8 reg0 mode0", ctrl_out[15:0], 16'h0020);
    chk("R8 reg5", ctrl_out[5*16 +: 16], 16'h4F40);
    chk("R8 idle line", sda_oe, 1'b0);
    // R8: defaults with mode_sel high
    mode_sel = 1'b1; rst_n = 1'b0; wclk(6); rst_n = 1'b1; wclk(2);
    model_reset(1'b1);
    chk("R8 reg0 mode1", ctrl_out[15:0], 16'h0021);
    chk("R8 reg46", ctrl_out[46*16 +: 16], 16'h2E2E);
    cmp_en = 1'b1; wclk(10);

    // R1: foreign address gets no ack and its bytes are ignored
    bus_start();
    send_byte({7'b1101011, 1'b0}, ack); chk("R1 foreign addr nack", ack, 1'b0);
    send_byte(8'h01, ack); chk("R1 ignored pointer", ack, 1'b0);
    send_byte(8'h12, ack); chk("R1 ignored data", ack, 1'b0);
    send_byte(8'h34, ack); chk("R1 ignored data", ack, 1'b0);
    bus_stop();

    // R3 R4: two-word burst from 0x03
    wq = '{16'hA1B2, 16'hC3D4};
    write_burst(7'b1101001, 3, wq);
    // R5 R6 R7: read back three words
    read_burst(7'b1101001, 3, 3, "R5 R6 read word");

    // R3: lone high byte then STOP leaves register intact
    bus_start();
    send_byte({7'b1101001, 1'b0}, ack); chk("R2 addr ack", ack, 1'b1);
    send_byte(8'h05, ack); chk("R2 pointer ack", ack, 1'b1);
    send_byte(8'hEE, ack); chk("R3 high ack", ack, 1'b1);
    bus_stop();
    read_burst(7'b1101001, 5, 1, "R3 half word ignored");

    // R9: burst from last control register runs into status
    wq = '{16'h7777, 16'h5555, 16'h6666};
    write_burst(7'b1101001, 46, wq);
    read_burst(7'b1101001, 46, 4, "R9 status and edge");

    // R10: unmapped addresses
    wq = '{16'h9999};
    write_burst(7'b1101001, 8'h40, wq);
    read_burst(7'b1101001, 8'h40, 1, "R10 unmapped read");

    // R11: repeated START halfway through a data byte
    bus_start();
    send_byte({7'b1101001, 1'b0}, ack); chk("R11 addr ack", ack, 1'b1);
    send_byte(8'h01, ack); chk("R11 pointer ack", ack, 1'b1);
    send_byte(8'h11, ack); chk("R11 high ack", ack, 1'b1);
    send_bits(8'hAB, 4);
    bus_rstart();
    send_byte({7'b1101001, 1'b0}, ack); chk("R11 fresh addr ack", ack, 1'b1);
    send_byte(8'h02, ack); chk("R11 pointer ack", ack, 1'b1);
    send_byte(8'h5A, ack); chk("R11 high ack", ack, 1'b1);
    send_byte(8'hC3, ack); chk("R11 low ack", ack, 1'b1);
    mdl[2] = 16'h5AC3;
    bus_stop();
    read_burst(7'b1101001, 1, 2, "R11 partial byte dropped");

    // R1: strap change moves the address
    strap = 2'b10;
    wq = '{16'h0F0F};
    write_burst(7'b1101010, 6, wq);
    bus_start();
    send_byte({7'b1101001, 1'b0}, ack); chk("R1 old strap addr nack", ack, 1'b0);
    bus_stop();
    read_burst(7'b1101010, 6, 1, "R1 new strap read");

    chk("R12 sda_oe moves only with scl low", r12_bad, 0);
    wclk(10);
    summary_and_end();
  end
endmodule